// File: doc/BRIEF.md
# LLR Vector Normalization Unit

This block sits in front of the check node processor of a nonbinary LDPC decoder. Each beat carries one variable-to-check message: a vector of `Q` unsigned reliability values, one per field symbol. A smaller value means a more likely symbol. The block finds the smallest value and the symbol that holds it, then subtracts that value from every entry. The result is a vector whose smallest entry is exactly zero, sent out together with the winning symbol index.

Each input beat also carries a last-iteration tag. When a tagged beat leaves the block, the winning symbol is also strobed onto a separate hard-decision pair. An output memory can capture it there. During that final pass the arithmetic upstream is idle, so this strobe is the decoder's decision path. The normalized beat itself still goes to the check node processor as usual.

Both data edges are valid/ready streams:
- A beat moves when valid and ready are high in the same cycle.
- A source holding valid must keep its data stable until the beat is taken.
- The output side follows the same rule.
- The block holds at most two beats. It stops taking input only when both register stages are full and the consumer holds ready low.

Top module: `llrn_norm`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `hd_valid` are 0 and `in_ready` is 1.
- R2: `out_idx` is the index of the smallest entry of the input vector. Entry i lies at `in_llr[i*W +: W]` and stands for symbol i.
- R3: Each output entry i equals input entry i minus the minimum, as an unsigned value. The entry at `out_idx` is therefore zero.
- R4: When several entries share the minimum, `out_idx` is the lowest such index, so no output entry below `out_idx` is zero.
- R5: A beat taken in cycle c appears on the output in cycle c+2 when nothing stalls. Beats can be taken on every cycle.
- R6: Back-pressure rules:
  - While `out_valid` is high and `out_ready` is low, the output beat is held unchanged.
  - `in_ready` is low only when two beats are in flight and `out_ready` is low.
  - No beat is lost, duplicated or reordered.
- R7: `hd_valid` is high in exactly those cycles in which a last-tagged beat leaves the block (`out_valid` and `out_ready` both high), and `hd_sym` then equals `out_idx`.
- R8: A beat without the last tag never raises `hd_valid`. The tag has no effect on `out_llr` or `out_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_llr | input | Q*W | Incoming vector, entry i at bits i*W +: W |
| in_last | input | 1 | Beat belongs to the final decoding iteration |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_llr | output | Q*W | Normalized vector, same layout as the input |
| out_idx | output | $clog2(Q) | Symbol holding the minimum |
| hd_valid | output | 1 | Hard-decision strobe, one per final-iteration beat |
| hd_sym | output | $clog2(Q) | Hard-decision symbol |

## Verification
A comparison in the minimum tree with the wrong tie direction would show up at once on the first beat with a repeated minimum: `out_idx` points above a zero entry. A wrong subtraction would show in the same cycle as a nonzero entry at `out_idx`, or as entries that no longer equal input minus minimum. A broken stage-enable or a wrong occupancy rule would show as an output that changes while stalled, or as `in_ready` disagreeing with the count of beats in flight. A lost, duplicated or reordered beat would mismatch the next delivered vector. A last tag that is misaligned through the pipeline would show as a hard-decision strobe on the wrong beat, within two cycles of that beat leaving.

// File: rtl/llrn_pkg.sv
package llrn_pkg;
  localparam int unsigned LLRN_Q_DEF = 8;
  localparam int unsigned LLRN_W_DEF = 5;

  // tree levels resolved before the first pipeline register
  function automatic int first_levels(int q);
    return ($clog2(q) + 1) / 2;
  endfunction
endpackage

// File: rtl/llrn_reduce_level.sv
module llrn_reduce_level #(
  parameter int N  = 8,
  parameter int W  = 5,
  parameter int IW = 3
) (
  input  logic [N*W-1:0]      v_i,
  input  logic [N*IW-1:0]     x_i,
  output logic [(N/2)*W-1:0]  v_o,
  output logic [(N/2)*IW-1:0] x_o
);
  for (genvar p = 0; p < N/2; p++) begin : g_pair
    logic [W-1:0] lv, rv;
    logic         keep_l;
    assign lv = v_i[2*p*W +: W];
    assign rv = v_i[(2*p+1)*W +: W];
    // left candidate always carries the lower index: ties keep it
    assign keep_l = (lv <= rv);
    assign v_o[p*W +: W]   = keep_l ? lv : rv;
    assign x_o[p*IW +: IW] = keep_l ? x_i[2*p*IW +: IW] : x_i[(2*p+1)*IW +: IW];
  end
endmodule

// File: rtl/llrn_tree_part.sv
module llrn_tree_part #(
  parameter int N_IN   = 8,
  parameter int LEVELS = 2,
  parameter int W      = 5,
  parameter int IW     = 3,
  localparam int N_OUT = N_IN >> LEVELS
) (
  input  logic [N_IN*W-1:0]   v_i,
  input  logic [N_IN*IW-1:0]  x_i,
  output logic [N_OUT*W-1:0]  v_o,
  output logic [N_OUT*IW-1:0] x_o
);
  if (LEVELS == 0) begin : g_pass
    assign v_o = v_i;
    assign x_o = x_i;
  end else begin : g_tree
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int NI = N_IN >> l;
      logic [NI*W-1:0]      vi;
      logic [NI*IW-1:0]     xi;
      logic [(NI/2)*W-1:0]  vo;
      logic [(NI/2)*IW-1:0] xo;
      if (l == 0) begin : g_src
        assign vi = v_i;
        assign xi = x_i;
      end else begin : g_src
        assign vi = g_lvl[l-1].vo;
        assign xi = g_lvl[l-1].xo;
      end
      llrn_reduce_level #(.N(NI), .W(W), .IW(IW)) u_lvl (
        .v_i(vi), .x_i(xi), .v_o(vo), .x_o(xo)
      );
    end
    assign v_o = g_lvl[LEVELS-1].vo;
    assign x_o = g_lvl[LEVELS-1].xo;
  end
endmodule

// File: rtl/llrn_subtract.sv
module llrn_subtract #(
  parameter int Q = 8,
  parameter int W = 5
) (
  input  logic [Q*W-1:0] v_i,
  input  logic [W-1:0]   m_i,
  output logic [Q*W-1:0] v_o
);
  // every entry is >= m_i, so the unsigned difference never wraps
  for (genvar e = 0; e < Q; e++) begin : g_ent
    assign v_o[e*W +: W] = v_i[e*W +: W] - m_i;
  end
endmodule

// File: rtl/llrn_norm.sv
module llrn_norm #(
  parameter int Q = llrn_pkg::LLRN_Q_DEF,
  parameter int W = llrn_pkg::LLRN_W_DEF,
  localparam int IW = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [Q*W-1:0] in_llr,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [Q*W-1:0] out_llr,
  output logic [IW-1:0] out_idx,
  output logic          hd_valid,
  output logic [IW-1:0] hd_sym
);
  localparam int LV = $clog2(Q);
  localparam int L1 = llrn_pkg::first_levels(Q);
  localparam int L2 = LV - L1;
  localparam int NA = Q >> L1;

  // symbol labels entering the tree
  logic [Q*IW-1:0] idx0;
  for (genvar i = 0; i < Q; i++) begin : g_lbl
    assign idx0[i*IW +: IW] = IW'(i);
  end

  // stage A: first tree levels
  logic [NA*W-1:0]  pa_v;
  logic [NA*IW-1:0] pa_x;
  llrn_tree_part #(.N_IN(Q), .LEVELS(L1), .W(W), .IW(IW)) u_part_a (
    .v_i(in_llr), .x_i(idx0), .v_o(pa_v), .x_o(pa_x)
  );

  logic             a_v, a_last;
  logic [Q*W-1:0]   a_llr;
  logic [NA*W-1:0]  a_mv;
  logic [NA*IW-1:0] a_mi;

  logic b_v, b_last, b_take, a_take;
  assign b_take   = !b_v || out_ready;
  assign a_take   = !a_v || b_take;
  assign in_ready = a_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v    <= 1'b0;
      a_last <= 1'b0;
      a_llr  <= '0;
      a_mv   <= '0;
      a_mi   <= '0;
    end else if (a_take) begin
      a_v    <= in_valid;
      a_last <= in_last;
      a_llr  <= in_llr;
      a_mv   <= pa_v;
      a_mi   <= pa_x;
    end
  end

  // stage B: remaining levels and subtraction
  logic [W-1:0]   min_v;
  logic [IW-1:0]  min_i;
  logic [Q*W-1:0] norm;
  llrn_tree_part #(.N_IN(NA), .LEVELS(L2), .W(W), .IW(IW)) u_part_b (
    .v_i(a_mv), .x_i(a_mi), .v_o(min_v), .x_o(min_i)
  );
  llrn_subtract #(.Q(Q), .W(W)) u_sub (
    .v_i(a_llr), .m_i(min_v), .v_o(norm)
  );

  logic [Q*W-1:0] b_llr;
  logic [IW-1:0]  b_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_v    <= 1'b0;
      b_last <= 1'b0;
      b_llr  <= '0;
      b_idx  <= '0;
    end else if (b_take) begin
      b_v    <= a_v;
      b_last <= a_last;
      b_llr  <= norm;
      b_idx  <= min_i;
    end
  end

  assign out_valid = b_v;
  assign out_llr   = b_llr;
  assign out_idx   = b_idx;
  assign hd_valid  = b_v && out_ready && b_last;
  assign hd_sym    = b_idx;
endmodule

// File: rtl/llrn_norm_chk.sv
module llrn_norm_chk #(
  parameter int Q = 8,
  parameter int W = 5,
  localparam int IW = $clog2(Q)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Q*W-1:0] out_llr,
  input logic [IW-1:0]  out_idx,
  input logic           hd_valid,
  input logic [IW-1:0]  hd_sym
);
  logic zero_at, zero_below;
  always_comb begin
    zero_at    = 1'b0;
    zero_below = 1'b0;
    for (int e = 0; e < Q; e++) begin
      if (out_llr[e*W +: W] == '0) begin
        if (e == int'(out_idx)) zero_at = 1'b1;
        if (e < int'(out_idx))  zero_below = 1'b1;
      end
    end
  end

  // R3
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> zero_at);

  // R4
  tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !zero_below);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_llr) && $stable(out_idx)));

  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7
  hd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_valid |-> (out_valid && out_ready && hd_sym == out_idx));
endmodule

bind llrn_norm llrn_norm_chk #(.Q(Q), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_llr(out_llr), .out_idx(out_idx),
  .hd_valid(hd_valid), .hd_sym(hd_sym)
);

// File: tb/tb_llrn_norm.sv
module tb_llrn_norm;
  localparam int Q  = 8;
  localparam int W  = 5;
  localparam int IW = $clog2(Q);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [Q*W-1:0] in_llr = '0;
  logic in_ready, out_valid, hd_valid;
  logic [Q*W-1:0] out_llr;
  logic [IW-1:0] out_idx, hd_sym;

  always #10 clk = ~clk;

  llrn_norm #(.Q(Q), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_llr(out_llr), .out_idx(out_idx),
    .hd_valid(hd_valid), .hd_sym(hd_sym)
  );

  typedef struct packed {
    logic [Q*W-1:0] llr;
    logic [IW-1:0]  idx;
    logic           last;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit in_pending = 0, stall_prev = 0;
  logic [Q*W-1:0] prev_llr;
  logic [IW-1:0]  prev_idx;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [Q*W-1:0] v, input logic last);
    exp_t r;
    int mi = 0;
    int mv = v[W-1:0];
    for (int i = 1; i < Q; i++)
      if (int'(v[i*W +: W]) < mv) begin mv = v[i*W +: W]; mi = i; end
    for (int i = 0; i < Q; i++) r.llr[i*W +: W] = W'(int'(v[i*W +: W]) - mv);
    r.idx  = IW'(mi);
    r.last = last;
    return r;
  endfunction

  // per-cycle reference comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit o_fire, i_fire;
      o_fire = out_valid && out_ready;
      i_fire = in_valid && in_ready;
      // R6 occupancy rule for in_ready
      check(in_ready == !(exp_q.size() == 2 && !out_ready), "R6 in_ready",
            in_ready, !(exp_q.size() == 2 && !out_ready));
      check(!(out_valid && exp_q.size() == 0), "R6 spurious beat", out_valid, 0);
      if (stall_prev)
        check(out_valid && out_llr == prev_llr && out_idx == prev_idx,
              "R6 hold under stall", out_llr, prev_llr);
      if (o_fire && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_idx == e.idx, "R2 index", out_idx, e.idx);
        check(out_llr == e.llr, "R3 normalized vector", out_llr, e.llr);
        // R7 / R8
        check(hd_valid == e.last, "R7 hd_valid on transfer", hd_valid, e.last);
        if (hd_valid) check(hd_sym == e.idx, "R7 hd_sym", hd_sym, e.idx);
      end else begin
        check(!hd_valid, "R8 hd_valid without transfer", hd_valid, 0);
      end
      if (i_fire) exp_q.push_back(model(in_llr, in_last));
      stall_prev = out_valid && !out_ready;
      prev_llr   = out_llr;
      prev_idx   = out_idx;
      in_pending = in_valid && !in_ready;
    end
  end

  function automatic logic [Q*W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int a[8] = '{a0, a1, a2, a3, a4, a5, a6, a7};
    logic [Q*W-1:0] r;
    for (int i = 0; i < Q; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  task automatic send(input logic [Q*W-1:0] v, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_llr = v; in_last = last;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !hd_valid && in_ready, "R1 in reset",
          {out_valid, hd_valid, in_ready}, 3'b001);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(!out_valid && !hd_valid && in_ready, "R1 after reset",
          {out_valid, hd_valid, in_ready}, 3'b001);

    // R5 latency of an isolated beat
    out_ready = 1'b1;
    send(pack8(9, 4, 17, 4, 30, 12, 5, 8), 1'b0);
    @(negedge clk); in_valid = 1'b0;
    #2;
    check(!out_valid, "R5 not early", out_valid, 0);
    @(negedge clk); #2;
    check(out_valid && out_idx == 1, "R5 out at c+2", out_valid, 1);
    repeat (3) @(negedge clk);

    // directed patterns, back-to-back (R5 full rate)
    send(pack8(7, 7, 7, 7, 7, 7, 7, 7), 1'b0);        // R4 all tied -> 0
    send(pack8(31, 30, 29, 28, 27, 26, 25, 3), 1'b1); // R2 min at top, R7 last
    send(pack8(0, 31, 31, 31, 31, 31, 31, 0), 1'b0);  // R4 zeros at ends
    send(pack8(20, 19, 18, 2, 25, 24, 2, 9), 1'b1);   // R4 tie at 3 and 6
    send(pack8(31, 31, 31, 31, 31, 31, 31, 31), 1'b0);// R3 max values
    send(pack8(5, 6, 1, 8, 3, 1, 2, 1), 1'b1);        // R4 triple tie
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 directed drained", exp_q.size(), 0);

    // random stream with back-pressure (R6, R7, R8)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (c % 500 > 400) out_ready = 1'b0;
      if (!in_pending) begin
        logic [Q*W-1:0] v;
        int rng;
        rng = ($urandom % 2) ? 4 : 32;
        for (int i = 0; i < Q; i++) v[i*W +: W] = W'($urandom % rng);
        in_valid = ($urandom % 3) != 0;
        in_llr   = v;
        in_last  = ($urandom % 3) == 0;
      end
    end
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6 no beat lost", exp_q.size(), 0);
    finish_run();
  end
endmodule